// File: doc/BRIEF.md
# Bitmap Pixel Plot Engine

This block sets a single pixel inside a packed-pixel bitmap kept in video memory. A point is handed over as X/Y coordinates, a two-bit colour and a two-bit bitmap mode. The block turns these into a byte address and a pixel mask. It then performs a read-modify-write on that byte. Both halves of the read-modify-write use memory access slots. Slots arrive as a strobe together with the current horizontal column number.

The read runs in the first slot after the point is accepted. The returned byte is held in a latch. The write runs in a later slot, whose column must lie at least a fixed distance past the column of the read. A minimum column that lands past the end of the line carries over into the next line. The written byte keeps every bit outside the mask from the old byte. The bits inside the mask come from the colour, with its two bits repeated across the whole byte. When the write has gone out, the block signals completion for one cycle and is immediately free to take the next point.

The memory sits outside the block as a single-port RAM with one cycle of read latency. The cycle after a read is spent capturing the returned byte, so the latency never shows at the slot level.

Top module: `pixel_plot_engine`

## Requirements
- R1: `ready` is high exactly while the engine is idle. A point is taken in on a cycle with `start` and `ready` both high. `start` while busy is ignored. An idle engine never drives `mem_en`.
- R2: The read (`mem_en`=1, `mem_we`=0) happens in the first cycle with `slot_valid` high after the cycle of acceptance, whatever its column. No memory access happens before it.
- R3: The cycle right after the read never carries a memory access, even if a slot is offered. The byte on `mem_rdata` is captured in that cycle.
- R4: Let C be the read column. When C+24 is below 1368, the write (`mem_en`=1, `mem_we`=1) goes out in the first slot, after the capture cycle, whose column is at least C+24. Earlier slots go unused.
- R5: When C+24 is 1368 or more, the minimum column becomes C+24-1368. The write also waits until a slot with a column below C has been seen, marking the next line. That slot may be the one that carries the write.
- R6: Mode 0 (256 wide, 4 bit): address = (X>>1)+(Y<<7), mask = 0xF0 shifted right by 4·X[0].
- R7: Mode 1 (512 wide, 2 bit): address = (X>>2)+(Y<<7), mask = 0xC0 shifted right by 2·X[1:0].
- R8: Mode 2 (512 wide, 4 bit): address = (X>>1)+(Y<<8), with the mask of mode 0.
- R9: Mode 3 (256 wide, 8 bit): address = X+(Y<<8), mask = 0xFF. All addresses are taken modulo 2^16.
- R10: Write data = (old & ~mask) | (R & mask), where R is the two colour bits repeated into bit pairs 7:6, 5:4, 3:2 and 1:0.
- R11: `done` is high for exactly the one cycle after the write cycle. The engine is ready in that same cycle and can accept a new point in it.
- R12: After reset the engine is idle, with `ready` high, `done` low and no memory access, even while slots are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer a new point |
| pt_x | input | XW (9) | Pixel X coordinate |
| pt_y | input | YW (8) | Pixel Y coordinate |
| pt_mode | input | 2 | Bitmap mode, 0..3 as in R6 to R9 |
| pt_colour | input | 2 | Colour bits to replicate |
| ready | output | 1 | Engine idle, point may be offered |
| done | output | 1 | One-cycle pulse after the write |
| slot_valid | input | 1 | Memory access slot available this cycle |
| slot_col | input | CW (11) | Column number of the current slot |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (16) | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
Two events can fall on the same cycle. The completion pulse of one point can coincide with the acceptance of the next. A free slot can also coincide with the capture cycle that follows a read. The bench keeps `start` raised during every busy period, so each next point lands exactly on the completion cycle. Slots are offered in every cycle around the read, so a slot always falls on the capture cycle. A cycle-exact model of the slot rules judges both cases. It flags any access on the capture cycle, any lost or doubled point, and any write that does not sit in the first permitted slot. Directed reads at columns 1343, 1344 and 1349 cover the line wrap edge.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PM_N4 = 2'd0,
    PM_W2 = 2'd1,
    PM_W4 = 2'd2,
    PM_N8 = 2'd3
  } pix_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CAPT = 2'd2,
    ST_WRIT = 2'd3
  } plot_st_e;
endpackage

// File: rtl/ppe_addr_gen.sv
module ppe_addr_gen
  import ppe_pkg::*;
#(
  parameter int XW = 9,
  parameter int YW = 8,
  parameter int AW = 16
) (
  input  logic [XW-1:0]     px,
  input  logic [YW-1:0]     py,
  input  pix_mode_e         mode,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] mask
);
  logic [AW-1:0] xw;
  logic [AW-1:0] yw;

  assign xw = AW'(px);
  assign yw = AW'(py);

  // Address and pixel mask per packing mode
  always_comb begin
    addr = xw + (yw << 8);
    mask = 8'hFF;
    case (mode)
      PM_N4: begin
        addr = (xw >> 1) + (yw << 7);
        mask = 8'hF0 >> {px[0], 2'b00};
      end
      PM_W2: begin
        addr = (xw >> 2) + (yw << 7);
        mask = 8'hC0 >> {px[1:0], 1'b0};
      end
      PM_W4: begin
        addr = (xw >> 1) + (yw << 8);
        mask = 8'hF0 >> {px[0], 2'b00};
      end
      PM_N8: begin
        addr = xw + (yw << 8);
        mask = 8'hFF;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ppe_merge.sv
module ppe_merge
  import ppe_pkg::*;
(
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] mask,
  input  logic [1:0]        colour,
  output logic [BYTE_W-1:0] new_byte
);
  localparam int PAIRS = BYTE_W / 2;

  logic [BYTE_W-1:0] rep;

  // Spread the two colour bits over every bit pair
  for (genvar i = 0; i < PAIRS; i++) begin : g_rep
    assign rep[2*i +: 2] = colour;
  end

  assign new_byte = (old_byte & ~mask) | (rep & mask);
endmodule

// File: rtl/ppe_slot_gate.sv
module ppe_slot_gate #(
  parameter int CW   = 11,
  parameter int GAP  = 24,
  parameter int LINE = 1368
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_valid,
  input  logic [CW-1:0] slot_col,
  input  logic          load,
  output logic          permit
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum;
  logic [CW-1:0] min_q, min_d;
  logic [CW-1:0] rcol_q, rcol_d;
  logic          wrap_q, wrap_d;
  logic          new_line;
  logic          upd;

  assign sum      = {1'b0, slot_col} + SW'(GAP);
  assign new_line = slot_valid && (slot_col < rcol_q);
  assign upd      = load || new_line;

  // Next minimum column, folded into the next line when it overflows
  always_comb begin
    min_d  = min_q;
    rcol_d = rcol_q;
    wrap_d = wrap_q;
    if (load) begin
      rcol_d = slot_col;
      if (sum >= SW'(LINE)) begin
        min_d  = CW'(sum - SW'(LINE));
        wrap_d = 1'b1;
      end else begin
        min_d  = sum[CW-1:0];
        wrap_d = 1'b0;
      end
    end else if (new_line) begin
      wrap_d = 1'b0;
    end
  end

  assign permit = slot_valid && (!wrap_q || new_line) && (slot_col >= min_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '0;
      rcol_q <= '0;
      wrap_q <= 1'b0;
    end else if (upd) begin
      min_q  <= min_d;
      rcol_q <= rcol_d;
      wrap_q <= wrap_d;
    end
  end
endmodule

// File: rtl/pixel_plot_engine.sv
module pixel_plot_engine
  import ppe_pkg::*;
#(
  parameter int XW   = 9,
  parameter int YW   = 8,
  parameter int CW   = 11,
  parameter int AW   = 16,
  parameter int GAP  = 24,
  parameter int LINE = 1368
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XW-1:0]     pt_x,
  input  logic [YW-1:0]     pt_y,
  input  logic [1:0]        pt_mode,
  input  logic [1:0]        pt_colour,
  output logic              ready,
  output logic              done,
  input  logic              slot_valid,
  input  logic [CW-1:0]     slot_col,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  // Reset release aligned to the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  plot_st_e          st_q, st_d;
  logic [XW-1:0]     x_q;
  logic [YW-1:0]     y_q;
  pix_mode_e         mode_q;
  logic [1:0]        col_q;
  logic [BYTE_W-1:0] lat_q;
  logic              done_q;

  logic              accept;
  logic              rd_fire;
  logic              cap_en;
  logic              wr_fire;
  logic              permit;
  logic [BYTE_W-1:0] mask;
  logic [BYTE_W-1:0] merged;

  assign accept  = start && (st_q == ST_IDLE);
  assign rd_fire = (st_q == ST_READ) && slot_valid;
  assign cap_en  = (st_q == ST_CAPT);
  assign wr_fire = (st_q == ST_WRIT) && permit;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start)      st_d = ST_READ;
      ST_READ: if (slot_valid) st_d = ST_CAPT;
      ST_CAPT:                 st_d = ST_WRIT;
      ST_WRIT: if (permit)     st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      mode_q <= PM_N4;
      col_q  <= '0;
    end else if (accept) begin
      x_q    <= pt_x;
      y_q    <= pt_y;
      mode_q <= pix_mode_e'(pt_mode);
      col_q  <= pt_colour;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     lat_q <= '0;
    else if (cap_en) lat_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) done_q <= 1'b0;
    else         done_q <= wr_fire;
  end

  ppe_addr_gen #(.XW(XW), .YW(YW), .AW(AW)) u_addr (
    .px   (x_q),
    .py   (y_q),
    .mode (mode_q),
    .addr (mem_addr),
    .mask (mask)
  );

  ppe_merge u_merge (
    .old_byte (lat_q),
    .mask     (mask),
    .colour   (col_q),
    .new_byte (merged)
  );

  ppe_slot_gate #(.CW(CW), .GAP(GAP), .LINE(LINE)) u_gate (
    .clk        (clk),
    .rst_n      (srst_n),
    .slot_valid (slot_valid),
    .slot_col   (slot_col),
    .load       (rd_fire),
    .permit     (permit)
  );

  assign ready     = (st_q == ST_IDLE);
  assign done      = done_q;
  assign mem_en    = rd_fire || wr_fire;
  assign mem_we    = wr_fire;
  assign mem_wdata = merged;
endmodule

// File: rtl/ppe_chk.sv
module ppe_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic done,
  input logic slot_valid,
  input logic mem_en,
  input logic mem_we
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_en);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  // R2
  slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> slot_valid);

  // R3
  capture_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> !mem_en);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en && mem_we));
endmodule

bind pixel_plot_engine ppe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .ready      (ready),
  .done       (done),
  .slot_valid (slot_valid),
  .mem_en     (mem_en),
  .mem_we     (mem_we)
);

// File: tb/pixel_plot_engine_tb.sv
module pixel_plot_engine_tb;
  localparam int XW = 9, YW = 8, CW = 11, AW = 16, GAP = 24, LINE = 1368;

  logic          clk, rst_n, start, ready, done, slot_valid, mem_en, mem_we;
  logic [XW-1:0] pt_x;
  logic [YW-1:0] pt_y;
  logic [1:0]    pt_mode, pt_colour;
  logic [CW-1:0] slot_col;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  pixel_plot_engine #(.XW(XW), .YW(YW), .CW(CW), .AW(AW), .GAP(GAP), .LINE(LINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pt_x(pt_x), .pt_y(pt_y),
    .pt_mode(pt_mode), .pt_colour(pt_colour), .ready(ready), .done(done),
    .slot_valid(slot_valid), .slot_col(slot_col), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bench memory: 4096 bytes, aliased on the low address bits
  logic [7:0] ram [0:4095];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[11:0]];
    end
  end

  int n_cmp = 0, n_bad = 0, n_plot = 0, n_wr = 0;
  int col = 0;
  bit force_all = 1'b1, run = 1'b0, finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] f_addr(logic [8:0] x, logic [7:0] y, logic [1:0] m);
    int a;
    case (m)
      2'd0: a = (int'(x) >> 1) + (int'(y) << 7);
      2'd1: a = (int'(x) >> 2) + (int'(y) << 7);
      2'd2: a = (int'(x) >> 1) + (int'(y) << 8);
      default: a = int'(x) + (int'(y) << 8);
    endcase
    return a[15:0];
  endfunction

  function automatic logic [7:0] f_mask(logic [8:0] x, logic [1:0] m);
    case (m)
      2'd0, 2'd2: return x[0] ? 8'h0F : 8'hF0;
      2'd1: return 8'hC0 >> (2 * int'(x[1:0]));
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Cycle model of the plot sequence
  int phase = 0, rc = 0, minc = 0;
  bit need_wrap = 0, seen_wrap = 0, exp_done = 0, allowed;
  logic [8:0] cx; logic [7:0] cy; logic [1:0] cm, cc;
  logic [15:0] e_addr; logic [7:0] e_mask, e_wd, old;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      col = (col + 1) % LINE;
      slot_valid = force_all || ($urandom_range(0, 2) == 0);
      slot_col = CW'(col);
      #1;
      if (!rst_n) chk("R12", "no access in reset", int'(mem_en), 0);
      if (run) begin
        chk("R11", "done", int'(done), int'(exp_done));
        exp_done = 0;
        chk("R1", "ready", int'(ready), int'(phase == 0));
        case (phase)
          0: begin
            chk("R1", "idle access", int'(mem_en), 0);
            if (start && ready) begin
              cx = pt_x; cy = pt_y; cm = pt_mode; cc = pt_colour;
              phase = 1;
            end
          end
          1: begin
            if (slot_valid) begin
              e_addr = f_addr(cx, cy, cm);
              e_mask = f_mask(cx, cm);
              old = ram[e_addr[11:0]];
              e_wd = (old & ~e_mask) | ({4{cc}} & e_mask);
              chk("R2", "read strobe", int'({mem_en, mem_we}), 2);
              chk(mode_tag(cm), "read addr", int'(mem_addr), int'(e_addr));
              rc = col;
              need_wrap = (rc + GAP) >= LINE;
              minc = need_wrap ? rc + GAP - LINE : rc + GAP;
              seen_wrap = 0;
              phase = 2;
            end else chk("R2", "no access before read", int'(mem_en), 0);
          end
          2: begin
            chk("R3", "capture cycle quiet", int'(mem_en), 0);
            if (slot_valid && col < rc) seen_wrap = 1;
            phase = 3;
          end
          default: begin
            allowed = slot_valid && (!need_wrap || seen_wrap || col < rc) && col >= minc;
            if (allowed) begin
              chk(need_wrap ? "R5" : "R4", "write strobe", int'({mem_en, mem_we}), 3);
              chk(mode_tag(cm), "write addr", int'(mem_addr), int'(e_addr));
              chk("R10", "write data", int'(mem_wdata), int'(e_wd));
              exp_done = 1;
              n_wr++;
              phase = 0;
            end else begin
              chk(need_wrap ? "R5" : "R4", "write held", int'(mem_en), 0);
              if (slot_valid && col < rc) seen_wrap = 1;
            end
          end
        endcase
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic plot(input logic [8:0] x, input logic [7:0] y, input logic [1:0] m, input logic [1:0] c);
    pt_x = x; pt_y = y; pt_mode = m; pt_colour = c;
    start = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    n_plot++;
  endtask

  task automatic wait_idle();
    while (!ready || start) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_col(input int v);
    while (col != v) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < 4096; i++) ram[i] = 8'($urandom);
    rst_n = 1'b0; start = 1'b0; pt_x = '0; pt_y = '0; pt_mode = '0; pt_colour = '0;
    slot_valid = 1'b0; slot_col = '0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12: idle after reset with slots offered
    chk("R12", "ready after reset", int'(ready), 1);
    chk("R12", "done after reset", int'(done), 0);
    chk("R12", "no access after reset", int'(mem_en), 0);
    run = 1'b1;
    @(negedge clk);

    // R6..R9 and R10: every mode, every sub-byte position
    for (int m = 0; m < 4; m++)
      for (int x = 0; x < 4; x++)
        plot(9'(100 + x), 8'(m * 3 + 1), 2'(m), 2'(x));
    plot(9'd5, 8'd7, 2'd3, 2'b10);
    // R1: a start pulse while busy must be ignored
    pt_x = 9'd33; pt_y = 8'd44;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);

    // R4/R5: reads at columns 1343, 1344 and 1349
    wait_col(1341); plot(9'd10, 8'd2, 2'd0, 2'd3); wait_idle();
    wait_col(1342); plot(9'd11, 8'd2, 2'd1, 2'd1); wait_idle();
    wait_col(1347); plot(9'd12, 8'd2, 2'd2, 2'd2); wait_idle();

    // R11: back-to-back points, each accepted on the done cycle
    for (int i = 0; i < 6; i++) plot(9'(i * 7), 8'(i), 2'(i), 2'(i + 1));
    wait_idle();

    // Random points with sparse slots
    force_all = 1'b0;
    for (int i = 0; i < 300; i++) begin
      plot(9'($urandom), 8'($urandom), 2'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R1", "points written", n_wr, n_plot);
    finish_run();
  end
endmodule